// File: doc/BRIEF.md
# Rotating Register Base Remapper

This block converts architectural register numbers into physical register-file indices for a 128-entry register space. The upper part of that space rotates. Numbers 0 to 31 are mapped directly and never change. Numbers 32 to 127 are shifted by a base value and wrapped inside the 96-entry rotating window. Every read port and write port is translated in the same cycle, with no register stage in the path.

The base changes in three ways. A loop-iteration event steps it back by one, so a value written under one name in an iteration shows up one name higher in the next. A procedure call saves the current base on a small stack and advances it by a frame size, which lets caller and callee pass values in registers. A procedure return restores the saved base. The register storage itself and any spill or fill of saved frames live outside this block.

Top module: `rrb_remap`

## Requirements
- R1: An architectural number below 32 is output unchanged on its port, whatever the base.
- R2: An architectural number n from 32 to 127 maps to 32 + ((n - 32 + B) mod 96), where B is the current base. B always lies in 0..95.
- R3: All ports translate combinationally using the base held at the start of the cycle. A base change becomes visible only after the next rising clock edge. With no event asserted, the base and the saved-base stack keep their values.
- R4: A rotate event sets B to (B - 1) mod 96, so B = 0 becomes 95.
- R5: A call event with fewer than 4 saved bases pushes B and sets B to (B + (F mod 96)) mod 96, where F is the 7-bit frame size input.
- R6: A return event with at least one saved base restores B to the most recently saved base and removes that entry from the stack.
- R7: When several events are asserted in one cycle, only the highest-priority one is considered. Return has the highest priority, then call, then rotate.
- R8: A call while 4 bases are saved, and a return while none are saved, leave B and the stack unchanged.
- R9: After a synchronous active-low reset, B is 0 and the stack is empty, so every number maps to itself.
- R10: The same architectural number gives the same physical index on every read and write port in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_arch | input | 3x7 | Architectural numbers for the read ports |
| rd_phys | output | 3x7 | Physical indices for the read ports |
| wr_arch | input | 2x7 | Architectural numbers for the write ports |
| wr_phys | output | 2x7 | Physical indices for the write ports |
| rotate | input | 1 | Loop-iteration event: step the base back by one |
| call | input | 1 | Procedure entry: save the base and advance it by the frame size |
| ret | input | 1 | Procedure return: restore the last saved base |
| frame_size | input | 7 | Frame size used by a call event |

## Verification
The assertions assume that the event inputs are valid on every clock edge once reset has been released, and that the rotating window exactly fills the space above the direct registers. Frame sizes are not constrained: values of 96 and above are reduced, and the stimulus includes one such value. Each event is driven at the falling edge and held for exactly one rising edge, so every assertion sees single, well-defined events. Mixed events, and calls and returns at the stack limits, are applied on purpose so that the priority and ignore rules are exercised.

// File: rtl/rrb_pkg.sv
// Shared definitions for the rotating register base remapper.
// Assumes: consumers size their own vectors from their parameters.
package rrb_pkg;
    // Base-update event chosen for a cycle, after priority resolution.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_ROT  = 2'd1,
        EV_CALL = 2'd2,
        EV_RET  = 2'd3
    } rrb_event_e;
endpackage

// File: rtl/rrb_xlate.sv
// Maps one architectural register number to a physical index.
// Assumes: ROT_FIRST + ROT_SIZE == ARCH_REGS and base < ROT_SIZE.
module rrb_xlate #(
    parameter int ARCH_REGS = 128,
    parameter int ROT_FIRST = 32,
    parameter int ROT_SIZE  = 96,
    localparam int IDX_W    = $clog2(ARCH_REGS),
    localparam int BASE_W   = $clog2(ROT_SIZE)
) (
    input  logic [BASE_W-1:0] base,
    input  logic [IDX_W-1:0]  arch_idx,
    output logic [IDX_W-1:0]  phys_idx
);
    localparam int SUM_W = IDX_W + 2;

    logic [SUM_W-1:0] offset;
    logic [SUM_W-1:0] wrapped;

    // Offset into the rotating window, add the base, and wrap once.
    always_comb begin
        offset  = SUM_W'(arch_idx) - SUM_W'(ROT_FIRST) + SUM_W'(base);
        wrapped = (offset >= SUM_W'(ROT_SIZE)) ? offset - SUM_W'(ROT_SIZE) : offset;
        if (arch_idx < IDX_W'(ROT_FIRST))
            phys_idx = arch_idx;
        else
            phys_idx = IDX_W'(wrapped + SUM_W'(ROT_FIRST));
    end
endmodule

// File: rtl/rrb_evt_arb.sv
// Reduces the three event inputs to a single event, applying a fixed priority.
// Assumes: inputs are synchronous to the clock that consumes the result.
module rrb_evt_arb
    import rrb_pkg::*;
(
    input  logic       rotate,
    input  logic       call,
    input  logic       ret,
    output rrb_event_e evt
);
    // Priority: return over call over rotate.
    always_comb begin
        if (ret)         evt = EV_RET;
        else if (call)   evt = EV_CALL;
        else if (rotate) evt = EV_ROT;
        else             evt = EV_NONE;
    end
endmodule

// File: rtl/rrb_base_ctrl.sv
// Holds the rotating base and a bounded stack of bases saved by calls.
// Assumes: DEPTH >= 2. A call on a full stack or a return on an empty one is dropped.
module rrb_base_ctrl
    import rrb_pkg::*;
#(
    parameter int ROT_SIZE  = 96,
    parameter int DEPTH     = 4,
    parameter int FRAME_W   = 7,
    localparam int BASE_W   = $clog2(ROT_SIZE),
    localparam int SP_W     = $clog2(DEPTH + 1),
    localparam int PTR_W    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  rrb_event_e         evt,
    input  logic [FRAME_W-1:0] frame_size,
    output logic [BASE_W-1:0]  base_q,
    output logic [SP_W-1:0]    depth_q
);
    localparam int ADD_W = (BASE_W > FRAME_W ? BASE_W : FRAME_W) + 2;

    logic [BASE_W-1:0] saved [DEPTH];
    logic [ADD_W-1:0]  frame_red;
    logic [ADD_W-1:0]  call_sum;
    logic [BASE_W-1:0] call_base;
    logic [BASE_W-1:0] rot_base;
    logic              full;
    logic              empty;

    // Next-base candidates for the call and rotate events.
    always_comb begin
        frame_red = ADD_W'(frame_size);
        if (frame_red >= ADD_W'(ROT_SIZE))
            frame_red = frame_red - ADD_W'(ROT_SIZE);
        call_sum  = ADD_W'(base_q) + frame_red;
        if (call_sum >= ADD_W'(ROT_SIZE))
            call_sum = call_sum - ADD_W'(ROT_SIZE);
        call_base = BASE_W'(call_sum);
        rot_base  = (base_q == '0) ? BASE_W'(ROT_SIZE - 1) : base_q - BASE_W'(1);
        full      = (depth_q == SP_W'(DEPTH));
        empty     = (depth_q == '0);
    end

    // Base and stack-pointer update on the selected event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            depth_q <= '0;
        end else begin
            case (evt)
                EV_RET: if (!empty) begin
                    base_q  <= saved[PTR_W'(depth_q - SP_W'(1))];
                    depth_q <= depth_q - SP_W'(1);
                end
                EV_CALL: if (!full) begin
                    base_q  <= call_base;
                    depth_q <= depth_q + SP_W'(1);
                end
                EV_ROT:  base_q <= rot_base;
                default: ;
            endcase
        end
    end

    // Saved-base storage, written on an accepted call; it needs no reset.
    always_ff @(posedge clk) begin
        if (rst_n && evt == EV_CALL && !full)
            saved[PTR_W'(depth_q)] <= base_q;
    end
endmodule

// File: rtl/rrb_remap.sv
// Top of the rotating register base remapper: per-port translators plus base control.
// Assumes: ROT_FIRST + ROT_SIZE == ARCH_REGS. Translation is purely combinational.
module rrb_remap
    import rrb_pkg::*;
#(
    parameter int ARCH_REGS   = 128,
    parameter int ROT_FIRST   = 32,
    parameter int ROT_SIZE    = 96,
    parameter int NUM_RD      = 3,
    parameter int NUM_WR      = 2,
    parameter int STACK_DEPTH = 4,
    parameter int FRAME_W     = 7,
    localparam int IDX_W      = $clog2(ARCH_REGS),
    localparam int BASE_W     = $clog2(ROT_SIZE),
    localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_RD-1:0][IDX_W-1:0] rd_arch,
    output logic [NUM_RD-1:0][IDX_W-1:0] rd_phys,
    input  logic [NUM_WR-1:0][IDX_W-1:0] wr_arch,
    output logic [NUM_WR-1:0][IDX_W-1:0] wr_phys,
    input  logic                         rotate,
    input  logic                         call,
    input  logic                         ret,
    input  logic [FRAME_W-1:0]           frame_size
);
    rrb_event_e        evt;
    logic [BASE_W-1:0] base_q;
    logic [SP_W-1:0]   depth_q;

    rrb_evt_arb u_arb (
        .rotate (rotate),
        .call   (call),
        .ret    (ret),
        .evt    (evt)
    );

    rrb_base_ctrl #(
        .ROT_SIZE (ROT_SIZE),
        .DEPTH    (STACK_DEPTH),
        .FRAME_W  (FRAME_W)
    ) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .frame_size (frame_size),
        .base_q     (base_q),
        .depth_q    (depth_q)
    );

    // One translator per read port.
    for (genvar i = 0; i < NUM_RD; i++) begin : g_rd
        rrb_xlate #(
            .ARCH_REGS (ARCH_REGS),
            .ROT_FIRST (ROT_FIRST),
            .ROT_SIZE  (ROT_SIZE)
        ) u_xl (
            .base     (base_q),
            .arch_idx (rd_arch[i]),
            .phys_idx (rd_phys[i])
        );
    end

    // One translator per write port.
    for (genvar j = 0; j < NUM_WR; j++) begin : g_wr
        rrb_xlate #(
            .ARCH_REGS (ARCH_REGS),
            .ROT_FIRST (ROT_FIRST),
            .ROT_SIZE  (ROT_SIZE)
        ) u_xl (
            .base     (base_q),
            .arch_idx (wr_arch[j]),
            .phys_idx (wr_phys[j])
        );
    end
endmodule

// File: rtl/rrb_remap_chk.sv
// Property checker for rrb_remap, attached to the top with a bind.
// Assumes: event inputs are valid at every edge after reset.
module rrb_remap_chk #(
    parameter int ARCH_REGS   = 128,
    parameter int ROT_FIRST   = 32,
    parameter int ROT_SIZE    = 96,
    parameter int NUM_RD      = 3,
    parameter int NUM_WR      = 2,
    parameter int STACK_DEPTH = 4,
    localparam int IDX_W      = $clog2(ARCH_REGS),
    localparam int BASE_W     = $clog2(ROT_SIZE),
    localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_RD-1:0][IDX_W-1:0] rd_arch,
    input logic [NUM_RD-1:0][IDX_W-1:0] rd_phys,
    input logic [NUM_WR-1:0][IDX_W-1:0] wr_arch,
    input logic [NUM_WR-1:0][IDX_W-1:0] wr_phys,
    input logic                         rotate,
    input logic                         call,
    input logic                         ret,
    input logic [BASE_W-1:0]            base,
    input logic [SP_W-1:0]              depth
);
    for (genvar i = 0; i < NUM_RD; i++) begin : g_rd_chk
        assert_low_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_arch[i] < IDX_W'(ROT_FIRST)) |-> (rd_phys[i] == rd_arch[i]));
        assert_rot_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_arch[i] >= IDX_W'(ROT_FIRST)) |-> (rd_phys[i] >= IDX_W'(ROT_FIRST)));
    end

    assert_base_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        base < BASE_W'(ROT_SIZE));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rotate && !call && !ret) |=> ($stable(base) && $stable(depth)));

    assert_rotate_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate && !call && !ret) |=>
        (base == (($past(base) == '0) ? BASE_W'(ROT_SIZE - 1) : $past(base) - BASE_W'(1))));

    assert_call_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (call && !ret && depth < SP_W'(STACK_DEPTH)) |=> (depth == $past(depth) + SP_W'(1)));

    assert_ret_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && depth != '0) |=> (depth == $past(depth) - SP_W'(1)));

    assert_ret_over_rot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && rotate && depth == '0) |=> $stable(base));

    assert_call_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (call && !ret && depth == SP_W'(STACK_DEPTH)) |=> ($stable(base) && $stable(depth)));

    assert_ret_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && depth == '0) |=> ($stable(base) && $stable(depth)));

    assert_same_name_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_arch[0] == wr_arch[0]) |-> (rd_phys[0] == wr_phys[0]));
endmodule

bind rrb_remap rrb_remap_chk #(
    .ARCH_REGS   (ARCH_REGS),
    .ROT_FIRST   (ROT_FIRST),
    .ROT_SIZE    (ROT_SIZE),
    .NUM_RD      (NUM_RD),
    .NUM_WR      (NUM_WR),
    .STACK_DEPTH (STACK_DEPTH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_arch (rd_arch),
    .rd_phys (rd_phys),
    .wr_arch (wr_arch),
    .wr_phys (wr_phys),
    .rotate  (rotate),
    .call    (call),
    .ret     (ret),
    .base    (base_q),
    .depth   (depth_q)
);

// File: tb/rrb_remap_test.sv
`timescale 1ns/1ps
// Directed bench for rrb_remap: one task per scenario, with a model of the base and its stack.
module rrb_remap_test;
    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [2:0][6:0]      rd_arch = '0;
    logic [2:0][6:0]      rd_phys;
    logic [1:0][6:0]      wr_arch = '0;
    logic [1:0][6:0]      wr_phys;
    logic                 rotate = 1'b0;
    logic                 call = 1'b0;
    logic                 ret = 1'b0;
    logic [6:0]           frame_size = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Model of the base and the saved-base stack.
    int mb = 0;
    int mstk [4];
    int msp = 0;

    rrb_remap uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_arch    (rd_arch),
        .rd_phys    (rd_phys),
        .wr_arch    (wr_arch),
        .wr_phys    (wr_phys),
        .rotate     (rotate),
        .call       (call),
        .ret        (ret),
        .frame_size (frame_size)
    );

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    function automatic int expm(int n, int b);
        if (n < 32) return n;
        return 32 + ((n - 32 + b) % 96);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive a mix of numbers on every port and compare all of them with the model base.
    task automatic check_map(string req);
        rd_arch[0] = 7'd32;
        rd_arch[1] = 7'd127;
        rd_arch[2] = 7'd80;
        wr_arch[0] = 7'd5;
        wr_arch[1] = 7'd64;
        #1;
        chk(req, int'(rd_phys[0]), expm(32, mb));
        chk(req, int'(rd_phys[1]), expm(127, mb));
        chk(req, int'(rd_phys[2]), expm(80, mb));
        chk(req, int'(wr_phys[0]), expm(5, mb));
        chk(req, int'(wr_phys[1]), expm(64, mb));
    endtask

    // Apply one cycle of events, then advance the model following R4-R8.
    task automatic apply(bit r, bit c, bit t, int f);
        @(negedge clk);
        rotate = r; call = c; ret = t; frame_size = 7'(f);
        @(negedge clk);
        rotate = 1'b0; call = 1'b0; ret = 1'b0;
        if (t) begin
            if (msp > 0) begin msp--; mb = mstk[msp]; end
        end else if (c) begin
            if (msp < 4) begin mstk[msp] = mb; msp++; mb = (mb + (f % 96)) % 96; end
        end else if (r) begin
            mb = (mb + 95) % 96;
        end
    endtask

    task automatic t_reset;  // R9
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mb = 0; msp = 0;
        check_map("R9 reset identity");
    endtask

    task automatic t_rotate;  // R4, R2
        apply(1, 0, 0, 0);
        check_map("R4 rotate wrap 0->95");
        apply(1, 0, 0, 0);
        check_map("R4 rotate 95->94");
        chk("R2 arch 33 at base 94", expm(33, mb), 32 + 95);
    endtask

    task automatic t_pass;  // R1
        for (int v = 0; v < 32; v += 7) begin
            rd_arch[1] = 7'(v);
            wr_arch[1] = 7'(31 - v);
            #1;
            chk("R1 low read pass", int'(rd_phys[1]), v);
            chk("R1 low write pass", int'(wr_phys[1]), 31 - v);
        end
    endtask

    task automatic t_timing;  // R3
        @(negedge clk);
        rotate = 1'b1;
        rd_arch[0] = 7'd40;
        #1;
        chk("R3 same-cycle uses old base", int'(rd_phys[0]), expm(40, mb));
        @(negedge clk);
        rotate = 1'b0;
        mb = (mb + 95) % 96;
        #1;
        chk("R3 new base after edge", int'(rd_phys[0]), expm(40, mb));
        repeat (2) @(negedge clk);
        #1;
        chk("R3 idle holds base", int'(rd_phys[0]), expm(40, mb));
    endtask

    task automatic t_call_ret;  // R5, R6
        int b0;
        b0 = mb;
        apply(0, 1, 0, 10);
        check_map("R5 call frame 10");
        apply(0, 1, 0, 100);
        check_map("R5 call frame 100 reduced");
        apply(0, 0, 1, 0);
        check_map("R6 return restores inner");
        apply(0, 0, 1, 0);
        check_map("R6 return restores outer");
        chk("R6 base back to start", mb, b0);
    endtask

    task automatic t_limits;  // R8
        apply(0, 0, 1, 0);
        check_map("R8 return on empty ignored");
        for (int k = 0; k < 5; k++) apply(0, 1, 0, 3 + k);
        check_map("R8 call on full ignored");
        for (int k = 0; k < 4; k++) apply(0, 0, 1, 0);
        check_map("R8 unwound to start");
    endtask

    task automatic t_priority;  // R7
        apply(1, 1, 0, 20);
        check_map("R7 call beats rotate");
        apply(1, 1, 1, 20);
        check_map("R7 return beats call and rotate");
        apply(1, 0, 1, 0);
        check_map("R7 return on empty blocks rotate");
    endtask

    task automatic t_same;  // R10
        for (int v = 30; v < 128; v += 24) begin
            rd_arch[2] = 7'(v);
            wr_arch[0] = 7'(v);
            wr_arch[1] = 7'(v);
            #1;
            chk("R10 read vs write port 0", int'(rd_phys[2]), int'(wr_phys[0]));
            chk("R10 read vs write port 1", int'(rd_phys[2]), int'(wr_phys[1]));
            chk("R10 value matches map", int'(wr_phys[0]), expm(v, mb));
        end
    endtask

    initial begin
        t_reset();
        t_rotate();
        t_pass();
        t_timing();
        t_call_ret();
        t_limits();
        t_priority();
        t_same();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule